// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the arbitration and in-service bookkeeping core of an eight-input interrupt controller. It keeps a request register, an in-service register and a lowest-priority pointer. From these, together with a mask vector and a set of mode flags, it names the highest-priority eligible request and the highest-priority input that is still in service. Both results are combinational from the registers and the current inputs. A valid bit beside each index shows whether anything was found.

The surrounding controller decodes programming writes and turns them into strobes: an acknowledge for a given pin, an end-of-interrupt command (specific or non-specific), and a set-priority command. Priority is circular. The pin after the lowest-priority pointer is served first, so moving the pointer rotates the whole order. Four mode flags change the behaviour. Automatic end-of-interrupt skips in-service tracking. Rotation moves the pointer on each completion. Special mask mode lets the mask alone gate requests. Special fully-nested mode keeps the cascade input from blocking itself.

Top module: `irq_prio_core`

## Requirements
- R1: A request input sampled high at a clock edge sets its request bit from the next cycle on. The bit stays set after the input falls, until an acknowledge of that pin clears it.
- R2: A pin is eligible when its request bit is 1 and its mask bit is 0. With the pointer at 7, which is its reset value, the eligible pin with the lowest index is reported on pend_pin and pend_valid is 1.
- R3: Pins are scanned from pointer+1 (modulo 8) upward, wrapping round all eight. The first eligible pin in that order is reported.
- R4: When the scan meets a pin whose in-service bit is 1 before it meets an eligible pin, pend_valid is 0.
- R5: In special mask mode (smm_en=1) in-service bits do not block the pending scan. A non-specific end-of-interrupt then ignores in-service bits whose mask bit is 1.
- R6: In special fully-nested mode (sfn_en=1) in-service bit 2, the cascade input, does not block the pending scan.
- R7: isr_pin names the first set in-service bit in scan order, skipping masked bits in special mask mode. A non-specific end-of-interrupt (eoi_specific=0) clears that bit. It does nothing when isr_valid is 0.
- R8: A specific end-of-interrupt (eoi_specific=1) clears the in-service bit selected by eoi_level.
- R9: With rotate_en=1, the pin cleared by an end-of-interrupt becomes the new pointer. A set-priority strobe loads the pointer from prio_level.
- R10: An acknowledge of ack_pin clears its request bit only if req_in for that pin is low in that cycle. Without automatic end-of-interrupt it sets the pin's in-service bit.
- R11: With aeoi_en=1 an acknowledge leaves the in-service register unchanged. If rotate_en=1 as well, the acknowledged pin becomes the new pointer.
- R12: A synchronous active-high reset clears the request and in-service registers and sets the pointer to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Request input levels |
| mask_in | input | 8 | Mask bits, 1 disables a pin |
| aeoi_en | input | 1 | Automatic end-of-interrupt mode |
| rotate_en | input | 1 | Rotation on completion |
| smm_en | input | 1 | Special mask mode |
| sfn_en | input | 1 | Special fully-nested mode |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_pin | input | 3 | Pin being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_specific | input | 1 | 1 selects the specific form |
| eoi_level | input | 3 | Pin for a specific end-of-interrupt |
| prio_valid | input | 1 | Set-priority strobe |
| prio_level | input | 3 | New lowest-priority pin |
| pend_valid | output | 1 | An eligible request exists |
| pend_pin | output | 3 | Highest-priority eligible request |
| isr_valid | output | 1 | An in-service bit is found |
| isr_pin | output | 3 | Highest-priority in-service pin |
| req_out | output | 8 | Request register |
| isr_out | output | 8 | In-service register |

## Verification
Most faults in this block show up at the ports within one cycle. A wrong request or in-service bit appears directly on req_out or isr_out one cycle after the strobe that caused it. A wrong pointer has no output of its own. It shows up as a wrong pend_pin as soon as more than one pin is requesting, so the bench drives requests on every pattern under every pointer value. The bench compares all outputs against an arithmetic model after every cycle. An in-service bit cleared in error, or left set, changes whether pend_valid blocks lower levels, so the mode scenarios check blocking both before and after each completion.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    // Input that carries the downstream controller's cascaded request.
    localparam int unsigned CASCADE_PIN_DEF = 2;
    localparam int unsigned NUM_PINS_DEF    = 8;

    // Command precedence when strobes coincide on the pointer.
    typedef enum logic [1:0] {
        PTR_KEEP = 2'd0,
        PTR_ACK  = 2'd1,
        PTR_EOI  = 2'd2,
        PTR_SET  = 2'd3
    } ptr_src_e;
endpackage

// File: rtl/circ_scan.sv
module circ_scan #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] cand,
    input  logic [N-1:0] block,
    input  logic [W-1:0] start,
    output logic         hit,
    output logic [W-1:0] idx
);
    // Walk the ring from start; a blocking bit ends the walk with no hit.
    always_comb begin
        logic         stop;
        logic [W-1:0] pos;
        hit  = 1'b0;
        idx  = '0;
        stop = 1'b0;
        for (int i = 0; i < N; i++) begin
            pos = start + W'(i);
            if (!stop) begin
                if (block[pos]) begin
                    stop = 1'b1;
                end else if (cand[pos]) begin
                    hit  = 1'b1;
                    idx  = pos;
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_PINS    = NUM_PINS_DEF,
    parameter int unsigned CASCADE_PIN = CASCADE_PIN_DEF,
    localparam int unsigned W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] req_in,
    input  logic [NUM_PINS-1:0] mask_in,
    input  logic                aeoi_en,
    input  logic                rotate_en,
    input  logic                smm_en,
    input  logic                sfn_en,
    input  logic                ack_valid,
    input  logic [W-1:0]        ack_pin,
    input  logic                eoi_valid,
    input  logic                eoi_specific,
    input  logic [W-1:0]        eoi_level,
    input  logic                prio_valid,
    input  logic [W-1:0]        prio_level,
    output logic                pend_valid,
    output logic [W-1:0]        pend_pin,
    output logic                isr_valid,
    output logic [W-1:0]        isr_pin,
    output logic [NUM_PINS-1:0] req_out,
    output logic [NUM_PINS-1:0] isr_out
);
    localparam logic [W-1:0] PTR_RESET = W'(NUM_PINS - 1);

    typedef struct packed {
        logic [NUM_PINS-1:0] req;
        logic [NUM_PINS-1:0] isr;
        logic [W-1:0]        lp;
    } state_t;

    state_t st_q, st_d;

    logic [W-1:0]        scan_start;
    logic [NUM_PINS-1:0] pend_block;
    logic [NUM_PINS-1:0] isr_cand;
    logic                eoi_hit;
    logic [W-1:0]        eoi_target;
    ptr_src_e            ptr_src;

    assign scan_start = st_q.lp + W'(1);

    always_comb begin
        pend_block = st_q.isr;
        if (sfn_en)
            pend_block[CASCADE_PIN] = 1'b0;
        if (smm_en)
            pend_block = '0;
        isr_cand = smm_en ? (st_q.isr & ~mask_in) : st_q.isr;
    end

    circ_scan #(.N(NUM_PINS)) u_pend_scan (
        .cand  (st_q.req & ~mask_in),
        .block (pend_block),
        .start (scan_start),
        .hit   (pend_valid),
        .idx   (pend_pin)
    );

    circ_scan #(.N(NUM_PINS)) u_isr_scan (
        .cand  (isr_cand),
        .block ({NUM_PINS{1'b0}}),
        .start (scan_start),
        .hit   (isr_valid),
        .idx   (isr_pin)
    );

    always_comb begin
        eoi_hit    = eoi_valid && (eoi_specific || isr_valid);
        eoi_target = eoi_specific ? eoi_level : isr_pin;

        if (prio_valid)
            ptr_src = PTR_SET;
        else if (eoi_hit && rotate_en)
            ptr_src = PTR_EOI;
        else if (ack_valid && aeoi_en && rotate_en)
            ptr_src = PTR_ACK;
        else
            ptr_src = PTR_KEEP;
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = st_q.req | req_in;
        if (ack_valid) begin
            if (!req_in[ack_pin])
                st_d.req[ack_pin] = 1'b0;
            if (!aeoi_en)
                st_d.isr[ack_pin] = 1'b1;
        end
        if (eoi_hit)
            st_d.isr[eoi_target] = 1'b0;
        unique case (ptr_src)
            PTR_SET:  st_d.lp = prio_level;
            PTR_EOI:  st_d.lp = eoi_target;
            PTR_ACK:  st_d.lp = ack_pin;
            default:  st_d.lp = st_q.lp;
        endcase
        if (rst) begin
            st_d.req = '0;
            st_d.isr = '0;
            st_d.lp  = PTR_RESET;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req_out = st_q.req;
    assign isr_out = st_q.isr;

    AST_REQ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !ack_valid |=> ((st_q.req & $past(req_in)) == $past(req_in))); // R1
    AST_PEND_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> (st_q.req[pend_pin] && !mask_in[pend_pin])); // R2
    AST_SMM_UNBLOCKED: assert property (@(posedge clk) disable iff (rst)
        (smm_en && ((st_q.req & ~mask_in) != '0)) |-> pend_valid); // R5
    AST_ISR_TOP_SET: assert property (@(posedge clk) disable iff (rst)
        isr_valid |-> st_q.isr[isr_pin]); // R7
    AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && eoi_specific && !ack_valid) |=> !st_q.isr[$past(eoi_level)]); // R8
    AST_AEOI_ISR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && aeoi_en && !eoi_valid) |=> $stable(st_q.isr)); // R11
endmodule

// File: tb/irq_prio_core_test.sv
module irq_prio_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0, mask_in = '0;
    logic       aeoi_en = 0, rotate_en = 0, smm_en = 0, sfn_en = 0;
    logic       ack_valid = 0, eoi_valid = 0, eoi_specific = 0, prio_valid = 0;
    logic [2:0] ack_pin = '0, eoi_level = '0, prio_level = '0;
    logic       pend_valid, isr_valid;
    logic [2:0] pend_pin, isr_pin;
    logic [7:0] req_out, isr_out;

    int n_checks = 0, n_fail = 0, cyc = 0;
    logic [7:0] m_req = '0, m_isr = '0;
    int         m_lp = 7;

    always #5 clk = ~clk;

    irq_prio_core uut (
        .clk(clk), .rst(rst), .req_in(req_in), .mask_in(mask_in),
        .aeoi_en(aeoi_en), .rotate_en(rotate_en), .smm_en(smm_en), .sfn_en(sfn_en),
        .ack_valid(ack_valid), .ack_pin(ack_pin), .eoi_valid(eoi_valid),
        .eoi_specific(eoi_specific), .eoi_level(eoi_level),
        .prio_valid(prio_valid), .prio_level(prio_level),
        .pend_valid(pend_valid), .pend_pin(pend_pin), .isr_valid(isr_valid),
        .isr_pin(isr_pin), .req_out(req_out), .isr_out(isr_out)
    );

    function automatic int ref_pend();
        logic [7:0] blk = m_isr;
        if (sfn_en) blk[2] = 1'b0;
        if (smm_en) blk = '0;
        for (int i = 0; i < 8; i++) begin
            int p = (m_lp + 1 + i) % 8;
            if (blk[p]) return -1;
            if (m_req[p] && !mask_in[p]) return p;
        end
        return -1;
    endfunction

    function automatic int ref_isr();
        for (int i = 0; i < 8; i++) begin
            int p = (m_lp + 1 + i) % 8;
            if (m_isr[p] && !(smm_en && mask_in[p])) return p;
        end
        return -1;
    endfunction

    task automatic check(input string tag);
        int ep = ref_pend();
        int ei = ref_isr();
        n_checks++;
        if (pend_valid !== (ep >= 0) || (ep >= 0 && pend_pin !== 3'(ep))) begin
            n_fail++;
            $display("FAIL %s pend: got v=%0b pin=%0d exp pin=%0d", tag, pend_valid, pend_pin, ep);
        end
        n_checks++;
        if (isr_valid !== (ei >= 0) || (ei >= 0 && isr_pin !== 3'(ei))) begin
            n_fail++;
            $display("FAIL %s isr_pin: got v=%0b pin=%0d exp pin=%0d", tag, isr_valid, isr_pin, ei);
        end
        n_checks++;
        if (req_out !== m_req || isr_out !== m_isr) begin
            n_fail++;
            $display("FAIL %s regs: got req=%h isr=%h exp req=%h isr=%h", tag, req_out, isr_out, m_req, m_isr);
        end
    endtask

    // One clock edge: update model from driven inputs, drop strobes, compare.
    task automatic step(input string tag);
        logic [7:0] nreq, nisr;
        int nlp, tgt;
        @(posedge clk);
        nreq = m_req | req_in; nisr = m_isr; nlp = m_lp;
        if (ack_valid) begin
            if (!req_in[ack_pin]) nreq[ack_pin] = 1'b0;
            if (aeoi_en) begin
                if (rotate_en) nlp = ack_pin;
            end else nisr[ack_pin] = 1'b1;
        end
        if (eoi_valid) begin
            tgt = eoi_specific ? int'(eoi_level) : ref_isr();
            if (tgt >= 0) begin
                nisr[tgt] = 1'b0;
                if (rotate_en) nlp = tgt;
            end
        end
        if (prio_valid) nlp = prio_level;
        m_req = nreq; m_isr = nisr; m_lp = nlp;
        #1;
        ack_valid = 0; eoi_valid = 0; prio_valid = 0;
        #1;
        check(tag);
    endtask

    task automatic raise(input logic [7:0] pins, input string tag);
        req_in = pins; step(tag);
        req_in = '0;   step(tag);
    endtask
    task automatic ack(input int p, input string tag);
        ack_valid = 1; ack_pin = 3'(p); step(tag);
    endtask
    task automatic eoi(input bit spec, input int lvl, input string tag);
        eoi_valid = 1; eoi_specific = spec; eoi_level = 3'(lvl); step(tag);
    endtask
    task automatic setpri(input int lvl, input string tag);
        prio_valid = 1; prio_level = 3'(lvl); step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R12");
        rst = 0;
        raise(8'hFF, "R12");          // pointer 7 -> pin 0 first (R2)
        aeoi_en = 1;
        for (int p = 0; p < 8; p++) ack(p, "R11");
        aeoi_en = 0;

        // Sweep every pointer value against every request pattern (R2, R3).
        for (int lp = 0; lp < 8; lp++) begin
            setpri(lp, "R9");
            for (int pat = 1; pat < 256; pat++) begin
                mask_in = (lp % 2 == 1) ? 8'((pat * 37) & 8'h3C) : 8'h00;
                raise(8'(pat), "R3");
                mask_in = '0;
                aeoi_en = 1;
                for (int p = 0; p < 8; p++) if (pat[p]) ack(p, "R10");
                aeoi_en = 0;
            end
        end
        setpri(7, "R9");

        // In-service blocking and completions.
        raise(8'h28, "R1");
        ack(3, "R10");                // isr=08, pend none (R4)
        raise(8'h02, "R4");
        ack(1, "R10");
        eoi(0, 0, "R7");              // clears pin 1
        eoi(1, 3, "R8");              // clears pin 3
        // Special mask mode.
        ack(5, "R10");
        raise(8'h40, "R4");           // blocked by 5
        smm_en = 1; step("R5");
        mask_in = 8'h20; step("R5");
        eoi(0, 0, "R5");              // masked in-service bit skipped
        smm_en = 0; mask_in = '0; step("R5");
        eoi(1, 5, "R8");
        ack(6, "R10"); eoi(1, 6, "R8");
        // Special fully-nested mode on the cascade pin.
        raise(8'h04, "R6");
        ack(2, "R10");
        raise(8'h04, "R6");           // blocked by itself
        sfn_en = 1; step("R6");
        sfn_en = 0; step("R6");
        ack(2, "R10"); eoi(1, 2, "R8");
        // Acknowledge with the input still high keeps the request.
        req_in = 8'h10; step("R1");
        ack(4, "R10"); req_in = '0; step("R10");
        ack(4, "R10");
        eoi(1, 4, "R8");
        // Rotation.
        rotate_en = 1;
        raise(8'h10, "R9"); ack(4, "R10");
        eoi(0, 0, "R9");              // pointer -> 4
        raise(8'hFF, "R9");           // pin 5 first
        setpri(1, "R9");              // pin 2 first
        aeoi_en = 1;
        ack(2, "R11");                // pointer -> 2, isr unchanged
        ack(3, "R11");
        rotate_en = 0;
        for (int p = 0; p < 8; p++) ack(p, "R11");
        aeoi_en = 0;
        // Reset returns everything to its initial state.
        raise(8'h81, "R12"); ack(7, "R10");
        rst = 1; @(posedge clk); #1;
        m_req = '0; m_isr = '0; m_lp = 7; #1;
        check("R12");
        rst = 0;
        raise(8'hC0, "R12");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule